// File: doc/BRIEF.md
# Mains-Rate Minute Pulse Generator

This block divides a squared-up 60 Hz mains signal down to one narrow pulse per minute. Each high-to-low transition of the mains input advances a 12-bit binary count. When the count reaches the terminal value of 3600, the block raises a single-cycle pulse and returns the count to zero. The pulse therefore repeats every 3600 input periods, which is exactly one minute at 60 Hz.

The whole block runs on one system clock. The slow mains input first passes through a multi-flop synchronizer. A registered falling-edge detector then turns it into a one-cycle count enable. The terminal decode ANDs only the counter bits that are set in the terminal value. For 3600 these are bits 4, 9, 10 and 11, with weights 16, 512, 1024 and 2048. The counter starts at zero and clears at the terminal value, so it can never hold a larger value with those bits set. Because the decode is taken from registered state, it cannot glitch while bits change. The pulse output is registered as well. An active-high asynchronous reset clears everything, and the live count is exported for observation.

Top module: `minute_pulse_gen`

## Requirements
- R1: Each falling edge of `mains_i` raises `count_o` by exactly one. With the default two synchronizer stages, the new value appears on the fourth rising clock edge after the input changes.
- R2: A rising edge of `mains_i` leaves `count_o` unchanged.
- R3: While `rst_i` is high, `count_o` is 0 and `pulse_o` is 0 at once, with no clock edge needed.
- R4: The terminal decode tests only the bits that are set in TERM_CNT. For 3600 these are bits 4, 9, 10 and 11. No pulse is produced at any other count, and the value 3600 is shown for exactly one cycle.
- R5: On the clock edge after `count_o` shows 3600, `pulse_o` goes high for exactly one cycle and `count_o` becomes 0 on that same edge.
- R6: After any reset, the first pulse follows the 3600th falling edge, and later pulses follow every further 3600 falling edges.
- R7: `count_o` never exceeds TERM_CNT (3600).
- R8: Falling edges spaced only two system clocks apart are all counted. This includes the edge that arrives right after the terminal edge, which brings `count_o` to 1 one cycle after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| mains_i | input | 1 | Squared mains-frequency signal, asynchronous to clk_i |
| pulse_o | output | 1 | One-cycle pulse at the end of each terminal count |
| count_o | output | 12 | Current count of mains falling edges (CNT_W bits) |

## Verification
When the bench changes the mains input at a falling clock edge, the count is due four cycles later. The terminal pulse and the cleared count are due five cycles after the 3600th falling input. For every input transition, the driver pushes an item into a queue that holds the due cycle, the expected count and the expected pulse level. The monitor samples at falling clock edges and compares each item exactly in its due cycle; a pulse seen in any cycle where none is due is reported as an error. Reset is checked one time unit after assertion, before any clock edge, and the fast-toggle phase probes the edge that lands right behind the terminal clear.

// File: rtl/mp_pkg.sv
package mp_pkg;

   typedef enum logic {
      DEC_PARTIAL = 1'b0,
      DEC_FULL    = 1'b1
   } dec_mode_e;

   function automatic int unsigned ones_in(input longint unsigned v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 64; i++) n += int'(v[i]);
      return n;
   endfunction

endpackage

// File: rtl/mp_edge_sync.sv
module mp_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic din_i,
   output logic fall_o
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              fall_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_i or posedge rst_i) begin
               if (rst_i) sync_q[i] <= 1'b0;
               else       sync_q[i] <= din_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or posedge rst_i) begin
               if (rst_i) sync_q[i] <= 1'b0;
               else       sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         prev_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         prev_q <= sync_q[LAST];
         fall_q <= prev_q & ~sync_q[LAST];
      end
   end

   assign fall_o = fall_q;
endmodule

// File: rtl/mp_counter.sv
module mp_counter #(
   parameter int W = 12
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         inc_i,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)      cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/mp_term_decode.sv
module mp_term_decode
   import mp_pkg::*;
#(
   parameter int          W    = 12,
   parameter int unsigned TERM = 3600,
   parameter dec_mode_e   MODE = DEC_PARTIAL
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] cnt_i,
   output logic         hit_o,
   output logic         pulse_o
);
   localparam logic [W-1:0] MASK = W'(TERM);

   logic pulse_q;

   generate
      if (MODE == DEC_PARTIAL) begin : g_partial
         logic [W-1:0] sel;
         for (genvar i = 0; i < W; i++) begin : g_bit
            if (MASK[i]) begin : g_watch
               assign sel[i] = cnt_i[i];
            end else begin : g_skip
               assign sel[i] = 1'b1;
            end
         end
         assign hit_o = &sel;
      end else begin : g_full
         assign hit_o = (cnt_i == MASK);
      end
   endgenerate

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) pulse_q <= 1'b0;
      else       pulse_q <= hit_o;
   end

   assign pulse_o = pulse_q;
endmodule

// File: rtl/minute_pulse_gen.sv
module minute_pulse_gen
   import mp_pkg::*;
#(
   parameter int          CNT_W       = 12,
   parameter int unsigned TERM_CNT    = 3600,
   parameter int          SYNC_STAGES = 2,
   parameter dec_mode_e   DEC_MODE    = DEC_PARTIAL
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             mains_i,
   output logic             pulse_o,
   output logic [CNT_W-1:0] count_o
);
   localparam longint unsigned CNT_SPAN = longint'(1) << CNT_W;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("minute_pulse_gen: CNT_W must lie in 2..32");
      end
      if (TERM_CNT < 1 || longint'(TERM_CNT) >= CNT_SPAN) begin : g_bad_term
         $error("minute_pulse_gen: TERM_CNT must be nonzero and fit in CNT_W bits");
      end
      if (ones_in(longint'(TERM_CNT)) < 1) begin : g_bad_mask
         $error("minute_pulse_gen: terminal value has no set bit to decode");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("minute_pulse_gen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             step;
   logic             hit;
   logic [CNT_W-1:0] cnt;

   mp_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .din_i  (mains_i),
      .fall_o (step)
   );

   mp_counter #(
      .W (CNT_W)
   ) u_cnt (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .inc_i (step),
      .clr_i (hit),
      .cnt_o (cnt)
   );

   mp_term_decode #(
      .W    (CNT_W),
      .TERM (TERM_CNT),
      .MODE (DEC_MODE)
   ) u_dec (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .cnt_i   (cnt),
      .hit_o   (hit),
      .pulse_o (pulse_o)
   );

   assign count_o = cnt;
endmodule

// File: rtl/mp_pulse_chk.sv
module mp_pulse_chk #(
   parameter int          CNT_W    = 12,
   parameter int unsigned TERM_CNT = 3600
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             pulse_o,
   input logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM_CNT);

   AST_CNT_CEILING: assert property (@(posedge clk_i) disable iff (rst_i)
      count_o <= TERM_V); // R7

   AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
      (count_o != TERM_V) |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1)); // R1

   AST_TERM_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
      (count_o == TERM_V) |=> (count_o != TERM_V && pulse_o)); // R4

   AST_PULSE_AFTER_TERM: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_o |-> ($past(count_o) == TERM_V)); // R5

   AST_PULSE_NARROW: assert property (@(posedge clk_i) disable iff (rst_i)
      pulse_o |=> !pulse_o); // R5
endmodule

bind minute_pulse_gen mp_pulse_chk #(
   .CNT_W    (CNT_W),
   .TERM_CNT (TERM_CNT)
) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .pulse_o (pulse_o),
   .count_o (count_o)
);

// File: tb/tb_minute_pulse_gen.sv
module tb_minute_pulse_gen;
   localparam int TERM = 3600;
   localparam int LAT  = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b0;
   logic        mains = 1'b1;
   logic        pulse;
   logic [11:0] count;

   int    cyc = 0;
   int    checks = 0;
   int    bad = 0;
   int    cnt_m = 0;
   int    max_seen = 0;
   bit    done = 1'b0;

   int    q_due[$];
   int    q_cnt[$];
   bit    q_pls[$];
   string q_tag[$];

   minute_pulse_gen dut (
      .clk_i   (clk),
      .rst_i   (rst),
      .mains_i (mains),
      .pulse_o (pulse),
      .count_o (count)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic push(input int due, input int c, input bit p, input string tag);
      q_due.push_back(due);
      q_cnt.push_back(c);
      q_pls.push_back(p);
      q_tag.push_back(tag);
   endtask

   task automatic fall_edge(input int hold);
      @(negedge clk);
      mains = 1'b0;
      cnt_m++;
      if (cnt_m == TERM) begin
         push(cyc + LAT, TERM, 1'b0, "R4");
         push(cyc + LAT + 1, 0, 1'b1, "R5");
         cnt_m = 0;
      end else begin
         push(cyc + LAT, cnt_m, 1'b0, "R1");
      end
      repeat (hold - 1) @(negedge clk);
   endtask

   task automatic rise_edge(input int hold, input bit track);
      @(negedge clk);
      mains = 1'b1;
      if (track) push(cyc + LAT, cnt_m, 1'b0, "R2");
      repeat (hold - 1) @(negedge clk);
   endtask

   task automatic slow_periods(input int n);
      for (int i = 0; i < n; i++) begin
         fall_edge(3);
         rise_edge(3, 1'b1);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      #1;
      checks++;
      if (count !== 12'd0 || pulse !== 1'b0) begin
         bad++;
         $display("FAIL R3 reset: count=%0d pulse=%0b expected count=0 pulse=0", count, pulse);
      end
      q_due.delete(); q_cnt.delete(); q_pls.delete(); q_tag.delete();
      cnt_m = 0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // monitor: compares scoreboard items in their due cycle
   always @(negedge clk) begin
      bit exp_p;
      exp_p = 1'b0;
      if (!rst) begin
         while (q_due.size() > 0 && q_due[0] <= cyc) begin
            int    d;
            int    c;
            bit    p;
            string t;
            d = q_due.pop_front(); c = q_cnt.pop_front();
            p = q_pls.pop_front(); t = q_tag.pop_front();
            checks++;
            if (d != cyc || int'(count) != c || pulse !== p) begin
               bad++;
               $display("FAIL %s cycle %0d: count=%0d pulse=%0b expected count=%0d pulse=%0b due=%0d",
                        t, cyc, count, pulse, c, p, d);
            end
            if (p) exp_p = 1'b1;
         end
         if (pulse === 1'b1 && !exp_p) begin
            checks++; bad++;
            $display("FAIL R4 unexpected pulse at cycle %0d: count=%0d expected pulse=0", cyc, count);
         end
         if (int'(count) > TERM) begin
            checks++; bad++;
            $display("FAIL R7 count=%0d expected at most %0d", count, TERM);
         end
         if (int'(count) > max_seen) max_seen = int'(count);
      end
   end

   initial begin
      #1 rst = 1'b1;
      #5;
      checks++;
      if (count !== 12'd0 || pulse !== 1'b0) begin
         bad++;
         $display("FAIL R3 initial reset: count=%0d pulse=%0b expected 0/0", count, pulse);
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (4) @(negedge clk);

      // R1 R2 R4 R5 R6: first full minute from reset, then a second one
      slow_periods(TERM);
      slow_periods(TERM);

      // R3 R6: reset in the middle of a count, then a full minute again
      slow_periods(1000);
      do_reset();
      slow_periods(TERM);

      // R8: approach terminal slowly, then toggle every system clock
      slow_periods(TERM - 3);
      for (int i = 0; i < 8; i++) begin
         fall_edge(1);
         rise_edge(1, 1'b0);
      end
      repeat (12) @(negedge clk);
      checks++;
      if (cnt_m != 5 || int'(count) != 5) begin
         bad++;
         $display("FAIL R8 fast edges: count=%0d model=%0d expected 5", count, cnt_m);
      end

      checks++;
      if (max_seen != TERM) begin
         bad++;
         $display("FAIL R7 max count=%0d expected %0d", max_seen, TERM);
      end
      checks++;
      if (q_due.size() != 0) begin
         bad++;
         $display("FAIL R1 pending items=%0d expected 0", q_due.size());
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; bad++;
         $display("FAIL watchdog: run not finished, expected completion");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule